// File: doc/BRIEF.md
# Two-Wire Byte Memory Target

This block is a target on a two-wire serial bus that fronts a byte-wide memory held in a register array. A bus controller selects it with a control byte carrying a fixed device code, three select bits that must equal the `devSel` pins, and a direction bit. After selection the controller can store a single byte at a two-byte address, fetch the byte at a two-byte address, or fetch a byte with no address phase at all. The last form returns the location after the previous completed access.

The bus lines reach the block already synchronized to `clk`. The block pulls the data line low through `sdaOe`, so the line needs an external pull-up. All bus events are found by sampling both lines on `clk`. A start is the data line falling while the clock line is high. A stop is the data line rising while the clock line is high. A start or stop ends whatever transfer is in progress. The memory depth is `2**ADDR_W` bytes. Sixteen kilobytes needs `ADDR_W = 14`. The default is smaller, to keep the array compact.

Top module: `i2c_mem_target`

## Requirements
- R1: The control byte is, MSB first, the device code 1010, then three select bits, then the direction bit (1 = read). The block acknowledges it only when the code matches and the select bits equal `devSel`. It acknowledges by pulling the data line low during the ninth clock.
- R2: If the control byte does not match, the block never pulls the data line low. It ignores all later bytes until the next start, and a write sent in that state leaves the memory unchanged.
- R3: The address follows a write-direction control byte as two bytes, high byte first. Each byte is acknowledged. Only the low `ADDR_W` bits of the 16-bit value pick a location.
- R4: A data byte after the two address bytes is acknowledged and stored at that address.
- R5: A random read returns the stored byte at the given address, MSB first. A random read is a write-direction control byte, two address bytes, a repeated start, then a read-direction control byte.
- R6: A read-direction control byte with no address phase since the last stop returns the byte at n+1. Here n is the address of the last access completed with a stop.
- R7: The address after the top location (`2**ADDR_W - 1`) is 0.
- R8: The stored address moves only when a stop ends a transaction whose data byte finished. A stop in the middle of a byte leaves the stored address and the memory unchanged. The stored address after reset is undefined.
- R9: `sdaOe` changes only while the clock line is low. It is low after reset. The block releases the line after the acknowledge clock, and during the controller's acknowledge slot after a read byte.
- R10: A start seen in the middle of a byte abandons that byte. The next control byte is then decoded normally.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that samples the bus |
| rstN | input | 1 | Asynchronous active-low reset |
| sclIn | input | 1 | Synchronized bus clock line |
| sdaIn | input | 1 | Synchronized bus data line (wired value) |
| devSel | input | 3 | Select bits that the control byte must match |
| sdaOe | output | 1 | 1 pulls the data line low |

## Verification
A wrong bit counter shows up at once. The acknowledge moves off the ninth clock, so the controller sees a missing acknowledge or a corrupted byte within the same byte. A wrong state or a missed start or stop shows up as a stuck-low data line or a lost acknowledge in the very next transaction. A stale or early stored address cannot be seen until the next read with no address phase, which then returns a neighbouring location. For that reason the bench runs such reads directly after writes, after random reads, after aborted transfers and across the wrap point.

// File: rtl/i2c_mem_pkg.sv
package i2c_mem_pkg;

  localparam logic [3:0] DEV_CODE = 4'b1010;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CTRL,
    ST_AHI,
    ST_ALO,
    ST_WDAT,
    ST_RDAT,
    ST_DONE,
    ST_IGN
  } busState_e;

  // strobes from control to datapath, one cycle wide
  typedef struct packed {
    logic shiftIn;
    logic ldHi;
    logic ldLo;
    logic wrMem;
    logic useCur;
    logic txLoad;
    logic txShift;
    logic ackDrive;
    logic sdaRelease;
    logic commit;
  } dpStrobe_t;

endpackage

// File: rtl/i2c_mem_ctrl.sv
module i2c_mem_ctrl
  import i2c_mem_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       sclIn,
  input  logic       sdaIn,
  input  logic [2:0] devSel,
  input  logic [7:0] rxNext,
  output dpStrobe_t  strb,
  output busState_e  state,
  output logic [3:0] bitCnt
);

  localparam logic [3:0] LAST_BIT = 4'd7;
  localparam logic [3:0] ACK_SLOT = 4'd8;
  localparam logic [3:0] ACK_CLK  = 4'd9;

  logic sclD, sdaD;
  logic sclRise, sclFall, startDet, stopDet;
  logic readMode, addrSet;
  logic readModeN, addrSetN;
  busState_e stateN;
  logic [3:0] cntN;
  logic receiving, ctrlMatch;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclD <= 1'b1;
      sdaD <= 1'b1;
    end else begin
      sclD <= sclIn;
      sdaD <= sdaIn;
    end
  end

  assign sclRise  = sclIn & ~sclD;
  assign sclFall  = ~sclIn & sclD;
  assign startDet = sclIn & sclD & sdaD & ~sdaIn;
  assign stopDet  = sclIn & sclD & ~sdaD & sdaIn;

  assign receiving = (state == ST_CTRL) || (state == ST_AHI) ||
                     (state == ST_ALO)  || (state == ST_WDAT);
  assign ctrlMatch = (rxNext[7:1] == {DEV_CODE, devSel});

  always_comb begin
    stateN    = state;
    cntN      = bitCnt;
    readModeN = readMode;
    addrSetN  = addrSet;
    strb      = '0;
    if (stopDet) begin
      stateN          = ST_IDLE;
      cntN            = '0;
      addrSetN        = 1'b0;
      strb.sdaRelease = 1'b1;
      strb.commit     = (state == ST_DONE);
    end else if (startDet) begin
      stateN          = ST_CTRL;
      cntN            = '0;
      strb.sdaRelease = 1'b1;
    end else if (receiving || state == ST_RDAT) begin
      if (sclRise) begin
        if (bitCnt < ACK_SLOT) begin
          cntN         = bitCnt + 4'd1;
          strb.shiftIn = receiving;
          if (receiving && bitCnt == LAST_BIT) begin
            unique case (state)
              ST_CTRL: begin
                if (ctrlMatch) begin
                  readModeN   = rxNext[0];
                  strb.useCur = rxNext[0] & ~addrSet;
                end else begin
                  stateN = ST_IGN;
                end
              end
              ST_AHI:  strb.ldHi = 1'b1;
              ST_ALO: begin
                strb.ldLo = 1'b1;
                addrSetN  = 1'b1;
              end
              default: strb.wrMem = 1'b1;
            endcase
          end
        end else if (bitCnt == ACK_SLOT) begin
          cntN = ACK_CLK;
        end
      end else if (sclFall) begin
        if (bitCnt == ACK_SLOT) begin
          if (state == ST_RDAT) strb.sdaRelease = 1'b1;
          else                  strb.ackDrive   = 1'b1;
        end else if (bitCnt == ACK_CLK) begin
          cntN            = '0;
          strb.sdaRelease = 1'b1;
          unique case (state)
            ST_CTRL: begin
              if (readMode) begin
                stateN      = ST_RDAT;
                strb.txLoad = 1'b1;
              end else begin
                stateN = ST_AHI;
              end
            end
            ST_AHI:  stateN = ST_ALO;
            ST_ALO:  stateN = ST_WDAT;
            default: stateN = ST_DONE;
          endcase
        end else if (state == ST_RDAT && bitCnt != 4'd0) begin
          strb.txShift = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      bitCnt   <= '0;
      readMode <= 1'b0;
      addrSet  <= 1'b0;
    end else begin
      state    <= stateN;
      bitCnt   <= cntN;
      readMode <= readModeN;
      addrSet  <= addrSetN;
    end
  end

endmodule

// File: rtl/i2c_mem_dp.sv
module i2c_mem_dp
  import i2c_mem_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sdaIn,
  input  dpStrobe_t  strb,
  output logic [7:0] rxNext,
  output logic       sdaOe
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [7:0]        rxShift;
  logic [7:0]        hiByte;
  logic [7:0]        txReg;
  logic [ADDR_W-1:0] workAddr;
  logic [ADDR_W-1:0] curAddr;
  logic [ADDR_W-1:0] rxAddr;
  logic [7:0]        memRd;
  logic [7:0]        mem [DEPTH];

  assign rxNext = {rxShift[6:0], sdaIn};
  assign memRd  = mem[workAddr];

  // address formed from the high byte and the byte now completing
  generate
    if (ADDR_W > 8) begin : g_wide
      assign rxAddr = {hiByte[ADDR_W-9:0], rxNext};
    end else begin : g_narrow
      logic [7:0] unusedHi;
      assign unusedHi = hiByte;
      assign rxAddr   = rxNext[ADDR_W-1:0];
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxShift  <= '0;
      hiByte   <= '0;
      workAddr <= '0;
      curAddr  <= '0;
      txReg    <= '0;
      sdaOe    <= 1'b0;
    end else begin
      if (strb.shiftIn) rxShift <= rxNext;
      if (strb.ldHi)    hiByte  <= rxNext;
      if (strb.ldLo)    workAddr <= rxAddr;
      else if (strb.useCur) workAddr <= curAddr;
      if (strb.commit)  curAddr <= workAddr + 1'b1;
      if (strb.txLoad) begin
        txReg <= memRd;
        sdaOe <= ~memRd[7];
      end else if (strb.txShift) begin
        txReg <= {txReg[6:0], 1'b0};
        sdaOe <= ~txReg[6];
      end else if (strb.ackDrive) begin
        sdaOe <= 1'b1;
      end else if (strb.sdaRelease) begin
        sdaOe <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (strb.wrMem) mem[workAddr] <= rxNext;
  end

endmodule

// File: rtl/i2c_mem_target.sv
module i2c_mem_target
  import i2c_mem_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sclIn,
  input  logic       sdaIn,
  input  logic [2:0] devSel,
  output logic       sdaOe
);

  dpStrobe_t  strb;
  busState_e  ctrlState;
  logic [3:0] bitCnt;
  logic [7:0] rxNext;

  i2c_mem_ctrl u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .sclIn  (sclIn),
    .sdaIn  (sdaIn),
    .devSel (devSel),
    .rxNext (rxNext),
    .strb   (strb),
    .state  (ctrlState),
    .bitCnt (bitCnt)
  );

  i2c_mem_dp #(.ADDR_W(ADDR_W)) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .sdaIn  (sdaIn),
    .strb   (strb),
    .rxNext (rxNext),
    .sdaOe  (sdaOe)
  );

endmodule

// File: rtl/i2c_mem_target_chk.sv
module i2c_mem_target_chk
  import i2c_mem_pkg::*;
(
  input logic       clk,
  input logic       rstN,
  input logic       sclIn,
  input logic       sdaOe,
  input busState_e  state,
  input logic [3:0] bitCnt
);

  // R9
  sda_stable_scl_high_chk: assert property (@(posedge clk) disable iff (!rstN)
    (sclIn && $past(sclIn)) |-> $stable(sdaOe));

  // R9
  pull_after_fall_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sdaOe) |-> !$past(sclIn));

  // R2
  ignore_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IGN) |-> !sdaOe);

  // R10
  idle_released_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE) |-> !sdaOe);

  // R1
  bit_count_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    bitCnt <= 4'd9);

endmodule

bind i2c_mem_target i2c_mem_target_chk u_chk (
  .clk    (clk),
  .rstN   (rstN),
  .sclIn  (sclIn),
  .sdaOe  (sdaOe),
  .state  (ctrlState),
  .bitCnt (bitCnt)
);

// File: tb/i2c_mem_target_bench.sv
module i2c_mem_target_bench;

  localparam int AW    = 4;
  localparam int DEPTH = 1 << AW;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sclM = 1'b1;
  logic sdaM = 1'b1;
  logic [2:0] devSel = 3'b101;
  logic sdaOe;
  logic sdaBus;
  int   nChecks = 0;
  int   nFail = 0;
  logic [7:0] model [DEPTH];

  assign sdaBus = sdaM & ~sdaOe;

  always #5 clk = ~clk;

  i2c_mem_target #(.ADDR_W(AW)) u_i2c_mem_target (
    .clk    (clk),
    .rstN   (rstN),
    .sclIn  (sclM),
    .sdaIn  (sdaBus),
    .devSel (devSel),
    .sdaOe  (sdaOe)
  );

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  task automatic waitc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic busStart();
    sdaM = 1'b1; waitc(4);
    sclM = 1'b1; waitc(4);
    sdaM = 1'b0; waitc(4);
    sclM = 1'b0; waitc(4);
  endtask

  task automatic busStop();
    sdaM = 1'b0; waitc(4);
    sclM = 1'b1; waitc(4);
    sdaM = 1'b1; waitc(4);
  endtask

  task automatic sendBit(input logic b);
    sdaM = b; waitc(4);
    sclM = 1'b1; waitc(4);
    sclM = 1'b0;
  endtask

  task automatic sendByte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) sendBit(b[i]);
    sdaM = 1'b1; waitc(4);
    sclM = 1'b1; waitc(2);
    ack = ~sdaBus;
    waitc(2);
    sclM = 1'b0; waitc(4);
  endtask

  task automatic readByte(input logic mAck, output logic [7:0] b, output logic relOk);
    b = '0;
    sdaM = 1'b1;
    for (int i = 0; i < 8; i++) begin
      waitc(4);
      sclM = 1'b1; waitc(2);
      b = {b[6:0], sdaBus};
      waitc(2);
      sclM = 1'b0;
    end
    sdaM = ~mAck; waitc(4);
    sclM = 1'b1; waitc(2);
    relOk = ~sdaOe;
    waitc(2);
    sclM = 1'b0; waitc(4);
  endtask

  function automatic logic [7:0] ctrlByte(input logic [2:0] sel, input logic rd);
    return {4'b1010, sel, rd};
  endfunction

  task automatic writeMem(input logic [15:0] addr, input logic [7:0] d, output int acks);
    logic a;
    acks = 0;
    busStart();
    sendByte(ctrlByte(devSel, 1'b0), a); acks += int'(a);
    sendByte(addr[15:8], a); acks += int'(a);
    sendByte(addr[7:0], a); acks += int'(a);
    sendByte(d, a); acks += int'(a);
    busStop();
  endtask

  task automatic randRead(input logic [15:0] addr, output logic [7:0] d);
    logic a, rel;
    busStart();
    sendByte(ctrlByte(devSel, 1'b0), a);
    sendByte(addr[15:8], a);
    sendByte(addr[7:0], a);
    busStart();
    sendByte(ctrlByte(devSel, 1'b1), a);
    readByte(1'b0, d, rel);
    busStop();
  endtask

  task automatic curRead(output logic [7:0] d, output logic rel);
    logic a;
    busStart();
    sendByte(ctrlByte(devSel, 1'b1), a);
    readByte(1'b0, d, rel);
    busStop();
  endtask

  function automatic logic [15:0] mkAddr(input int a);
    // junk above the low AW bits must not matter (R3)
    return {8'hA0 ^ 8'(a * 5), 4'(a * 3 + 7), 4'(a)};
  endfunction

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    nChecks++;
    nFail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

  initial begin : stim
    logic a, rel;
    logic [7:0] d;
    int acks;
    waitc(5);
    // R9 reset state
    chk(sdaOe == 1'b0, "R9 reset release", int'(sdaOe), 0);
    rstN = 1'b1;
    waitc(4);

    // R1 select sweep: every pin setting against every select in the byte
    for (int p = 0; p < 8; p++) begin
      devSel = 3'(p);
      for (int s = 0; s < 8; s++) begin
        busStart();
        sendByte(ctrlByte(3'(s), 1'b0), a);
        busStop();
        chk(a == (s == p), "R1 select match", int'(a), int'(s == p));
      end
    end
    devSel = 3'b101;
    // R1 device code sweep
    for (int c = 0; c < 16; c++) begin
      busStart();
      sendByte({4'(c), devSel, 1'b0}, a);
      busStop();
      chk(a == (c == 10), "R1 device code", int'(a), int'(c == 10));
    end

    // R3 R4 write every location
    for (int i = 0; i < DEPTH; i++) begin
      model[i] = 8'(i * 37 + 91);
      writeMem(mkAddr(i), model[i], acks);
      chk(acks == 4, "R3 R4 write acks", acks, 4);
    end
    // R9 line released after the acknowledge clock
    busStart();
    sendByte(ctrlByte(devSel, 1'b0), a);
    chk(a && sdaOe == 1'b0, "R9 ack then release", int'(sdaOe), 0);
    busStop();

    // R5 random reads, descending order
    for (int i = DEPTH - 1; i >= 0; i--) begin
      randRead(mkAddr(i), d);
      chk(d == model[i], "R5 random read", int'(d), int'(model[i]));
    end

    // R6 R7 current-address chain crossing the top
    randRead(mkAddr(12), d);
    for (int k = 1; k <= 8; k++) begin
      curRead(d, rel);
      chk(d == model[(12 + k) % DEPTH], "R6 R7 current read", int'(d),
          int'(model[(12 + k) % DEPTH]));
      chk(rel, "R9 master ack slot released", int'(rel), 1);
    end

    // R7 write at top then current read gives location 0
    model[DEPTH-1] = 8'h3C;
    writeMem(mkAddr(DEPTH - 1), model[DEPTH-1], acks);
    curRead(d, rel);
    chk(d == model[0], "R7 wrap after write", int'(d), int'(model[0]));
    // R6 after a write at 6, read gives 7
    model[6] = 8'hE1;
    writeMem(mkAddr(6), model[6], acks);
    curRead(d, rel);
    chk(d == model[7], "R6 after write", int'(d), int'(model[7]));

    // R2 non-matching write ignored
    busStart();
    sendByte(ctrlByte(3'b001, 1'b0), a);
    chk(!a, "R2 no ack ctrl", int'(a), 0);
    sendByte(mkAddr(9) >> 8, a);
    chk(!a, "R2 no ack hi", int'(a), 0);
    sendByte(mkAddr(9), a);
    sendByte(8'h00, a);
    chk(!a, "R2 no ack data", int'(a), 0);
    busStop();
    randRead(mkAddr(9), d);
    chk(d == model[9], "R2 memory unchanged", int'(d), int'(model[9]));

    // R8 stop mid data byte: counter and memory untouched
    randRead(mkAddr(3), d);
    busStart();
    sendByte(ctrlByte(devSel, 1'b0), a);
    sendByte(8'h00, a);
    sendByte(8'h09, a);
    for (int i = 0; i < 4; i++) sendBit(1'b0);
    busStop();
    curRead(d, rel);
    chk(d == model[4], "R8 counter held", int'(d), int'(model[4]));
    randRead(mkAddr(9), d);
    chk(d == model[9], "R8 memory held", int'(d), int'(model[9]));

    // R10 start mid data byte, then read the set address
    busStart();
    sendByte(ctrlByte(devSel, 1'b0), a);
    sendByte(8'h00, a);
    sendByte(8'h02, a);
    for (int i = 0; i < 4; i++) sendBit(1'b1);
    busStart();
    sendByte(ctrlByte(devSel, 1'b1), a);
    chk(a, "R10 ctrl after abort", int'(a), 1);
    readByte(1'b0, d, rel);
    busStop();
    chk(d == model[2], "R10 read after abort", int'(d), int'(model[2]));
    // R10 start mid control byte
    busStart();
    for (int i = 0; i < 3; i++) sendBit(1'b1);
    curRead(d, rel);
    chk(d == model[3], "R10 current after aborted ctrl", int'(d), int'(model[3]));

    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

endmodule